// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. A write-side register strobe loads configuration, a baud divisor, transmit characters, commands and an interrupt mask. A read side returns status, the divisor, the received character and the mask. The transmitter sends a start bit, then 6, 7 or 8 data bits LSB first, an optional parity or address bit, and one stop bit. The receiver oversamples the line at 16 times the bit rate. It takes each bit as the majority of three samples near mid-bit.

Both directions share one frame format. Parity can be none, even, odd, forced low or forced high. In multidrop mode the parity slot carries a ninth bit instead, which tags the character as an address. The transmitter can hold the line low as a break on command, and the receiver recognises an all-low frame as a break. A channel-mode field routes the pins in one of four ways: normal, echo, internal loopback, or a pin-to-pin loop with the receiver cut off.

Top module: `sio_uart`

## Requirements
- R1: After reset, status (read address 0) is 0x0006: bit1 (transmit holding free) and bit2 (transmitter fully idle) set, all other bits clear. The line output txd is high and irq is low.
- R2: A transmitted frame is a 0 start bit, then the data bits LSB first, then the optional extra bit, then a 1 stop bit. Each bit lasts 16 × divisor clocks. The divisor is written at address 1. The length code is config bits [1:0]: 0 selects 6 data bits, 1 selects 7 and 2 selects 8.
- R3: Config bits [4:2] choose the extra bit. 0 means none, 1 means even parity, 2 means odd parity, 3 means a constant 0 and 4 means a constant 1. Parity is computed over the active data bits only.
- R4: With config bit 5 (multidrop) set, the extra slot carries bit 8 of the word written at address 2. A received ninth bit appears as bit 8 of the receive word. Status bit7 is set while that unread character has it set.
- R5: A completed character sets status bit0, and its data is read at address 2. A read there with rdEn high clears bit0.
- R6: A received extra bit that disagrees with the configured parity sets status bit5. This does not apply in multidrop mode.
- R7: A stop bit sampled low sets status bit4.
- R8: A character completing while bit0 is still set sets status bit3 and replaces the held character.
- R9: A frame-long low line is detected as a break. The frame includes its stop bit and all its bits are zero. A break sets status bit6 and does not set bit0. Command bit1 written at address 3 drives txd low, and command bit2 releases it.
- R10: Command bit0 at address 3 clears status bits 3 to 6.
- R11: Config bits [7:6] select the channel mode. 0 is normal. 1 is echo: txd follows rxd and the receiver still listens. 2 is local loop: txd stays high and the receiver hears the transmitter. 3 is remote loop: txd follows rxd and the receiver hears nothing.
- R12: irq is high exactly when some status bit and its mask bit are both set. The mask is written at address 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Read strobe; consumes the receive word at address 2 |
| rdData | output | 16 | Combinational read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
Transmit frames are captured at mid-bit for several combinations of length and parity: 8 bits with no parity, 7 bits with even parity, 6 bits with odd parity, a forced-high parity bit, and a multidrop address mark. This separates bit ordering, slot placement and parity polarity. Received frames cover a clean character, a wrong parity bit, a low stop bit, two unread characters in a row, a frame-long low and an address-tagged character. Each one should raise a different status bit. The three loop modes are compared every clock against a model of the pin routing, and the receive side is checked afterwards to tell echo from remote loop.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DIV_W = 16;
  localparam int MAX_DATA = 8;
  localparam int CHAR_W = MAX_DATA + 1;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0, MODE_ECHO = 2'd1, MODE_LOCAL = 2'd2, MODE_REMOTE = 2'd3
  } chanMode_e;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0, PAR_EVEN = 3'd1, PAR_ODD = 3'd2, PAR_ZERO = 3'd3, PAR_ONE = 3'd4
  } parMode_e;

  typedef struct packed {
    logic [1:0]       lenCode;
    parMode_e         parity;
    logic             multiDrop;
    chanMode_e        mode;
    logic [DIV_W-1:0] divisor;
  } cfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              txLoad;
    logic [CHAR_W-1:0] txData;
    logic              brkStart;
    logic              brkStop;
  } strobe_t;

  // datapath -> control events
  typedef struct packed {
    logic              rxDone;
    logic [CHAR_W-1:0] rxData;
    logic              parErr;
    logic              frameErr;
    logic              rxBrk;
    logic              txHoldFree;
    logic              txIdle;
  } event_t;

  function automatic int dataBits(input logic [1:0] code);
    case (code)
      2'd0:    return 6;
      2'd1:    return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic parityOn(input parMode_e p);
    return (p == PAR_EVEN) || (p == PAR_ODD) || (p == PAR_ZERO) || (p == PAR_ONE);
  endfunction

  function automatic logic extraBit(input cfg_t c, input logic [CHAR_W-1:0] d, input int n);
    logic [MAX_DATA-1:0] masked;
    masked = d[MAX_DATA-1:0] & (8'hFF >> (MAX_DATA - n));
    if (c.multiDrop) return d[MAX_DATA];
    case (c.parity)
      PAR_EVEN: return ^masked;
      PAR_ODD:  return ~^masked;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  strobe_t strb,
  input  logic    rxd,
  output logic    txd,
  output event_t  evt
);
  localparam int SUB_W   = $clog2(OSR);
  localparam int FRAME_W = MAX_DATA + 3;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam int MID     = OSR / 2;

  // baud tick at OSR times the bit rate
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (cfg.divisor != '0) && (divCnt == cfg.divisor - DIV_W'(1));
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) divCnt <= '0;
    else if (tick || cfg.divisor == '0) divCnt <= '0;
    else divCnt <= divCnt + DIV_W'(1);

  // frame geometry
  int nData;
  logic hasExtra;
  logic [IDX_W-1:0] frameLen;
  always_comb begin
    nData    = dataBits(cfg.lenCode);
    hasExtra = cfg.multiDrop || parityOn(cfg.parity);
    frameLen = IDX_W'(nData + 2 + int'(hasExtra));
  end

  // transmitter
  logic [FRAME_W-1:0] txShift, txFrame;
  logic [IDX_W-1:0]   txLeft;
  logic [SUB_W-1:0]   txSub;
  logic [CHAR_W-1:0]  txHold;
  logic txFull, brkOn, lineOut, rxIn;

  always_comb begin
    txFrame    = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < nData) txFrame[i+1] = txHold[i];
    if (hasExtra) txFrame[nData+1] = extraBit(cfg, txHold, nData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1; txLeft <= '0; txSub <= '0;
      txHold <= '0; txFull <= 1'b0; brkOn <= 1'b0;
    end else begin
      if (strb.brkStart) brkOn <= 1'b1;
      else if (strb.brkStop) brkOn <= 1'b0;
      if (strb.txLoad && !txFull) begin
        txHold <= strb.txData;
        txFull <= 1'b1;
      end
      if (txLeft == '0) begin
        if (txFull) begin
          txShift <= txFrame; txLeft <= frameLen; txSub <= '0; txFull <= 1'b0;
        end
      end else if (tick) begin
        txSub <= txSub + SUB_W'(1);
        if (txSub == SUB_W'(OSR - 1)) begin
          txShift <= {1'b1, txShift[FRAME_W-1:1]};
          txLeft  <= txLeft - IDX_W'(1);
        end
      end
    end
  end

  assign lineOut = brkOn ? 1'b0 : ((txLeft != '0) ? txShift[0] : 1'b1);
  assign evt.txHoldFree = !txFull;
  assign evt.txIdle = !txFull && (txLeft == '0);

  // channel-mode routing
  always_comb begin
    case (cfg.mode)
      MODE_ECHO:   begin txd = rxd;     rxIn = rxd;     end
      MODE_LOCAL:  begin txd = 1'b1;    rxIn = lineOut; end
      MODE_REMOTE: begin txd = rxd;     rxIn = 1'b1;    end
      default:     begin txd = lineOut; rxIn = rxd;     end
    endcase
  end

  // receiver
  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_WAITHIGH} rxState_e;
  rxState_e rxState;
  logic sync1, sync2, samp1, samp2, majBit;
  logic [SUB_W-1:0]   rxSub;
  logic [IDX_W-1:0]   rxIdx;
  logic [FRAME_W-1:0] rxBits, rxCur;
  logic [MAX_DATA-1:0] rxD;
  logic extraRx, stopRx, lastBit;
  logic rxDoneQ, parErrQ, frameErrQ, rxBrkQ;
  logic [CHAR_W-1:0] rxDataQ;

  assign majBit  = (samp1 & samp2) | (samp1 & sync2) | (samp2 & sync2);
  assign lastBit = (rxIdx == frameLen - IDX_W'(1));

  always_comb begin
    rxCur = rxBits;
    rxCur[rxIdx] = majBit;
    for (int i = 0; i < MAX_DATA; i++) rxD[i] = (i < nData) ? rxCur[i+1] : 1'b0;
    extraRx = rxCur[nData+1];
    stopRx  = rxCur[frameLen - IDX_W'(1)];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= 1'b1; sync2 <= 1'b1; samp1 <= 1'b1; samp2 <= 1'b1;
      rxState <= RX_IDLE; rxSub <= '0; rxIdx <= '0; rxBits <= '0;
      rxDoneQ <= 1'b0; parErrQ <= 1'b0; frameErrQ <= 1'b0; rxBrkQ <= 1'b0; rxDataQ <= '0;
    end else begin
      sync1 <= rxIn; sync2 <= sync1;
      rxDoneQ <= 1'b0; rxBrkQ <= 1'b0;
      if (tick) begin
        case (rxState)
          RX_IDLE: if (!sync2) begin
            rxState <= RX_BITS; rxSub <= SUB_W'(1); rxIdx <= '0; rxBits <= '0;
          end
          RX_BITS: begin
            rxSub <= rxSub + SUB_W'(1);
            if (rxSub == SUB_W'(MID - 1)) samp1 <= sync2;
            if (rxSub == SUB_W'(MID)) samp2 <= sync2;
            if (rxSub == SUB_W'(OSR - 1)) rxIdx <= rxIdx + IDX_W'(1);
            if (rxSub == SUB_W'(MID + 1)) begin
              if (rxIdx == '0 && majBit) rxState <= RX_IDLE;
              else begin
                rxBits[rxIdx] <= majBit;
                if (lastBit) begin
                  if (rxCur == '0) begin
                    rxBrkQ <= 1'b1; rxState <= RX_WAITHIGH;
                  end else begin
                    rxDoneQ   <= 1'b1;
                    rxDataQ   <= {cfg.multiDrop & extraRx, rxD};
                    frameErrQ <= !stopRx;
                    parErrQ   <= !cfg.multiDrop && parityOn(cfg.parity) &&
                                 (extraRx != extraBit(cfg, {1'b0, rxD}, nData));
                    rxState   <= RX_IDLE;
                  end
                end
              end
            end
          end
          default: if (sync2) rxState <= RX_IDLE;
        endcase
      end
    end
  end

  assign evt.rxDone   = rxDoneQ;
  assign evt.rxData   = rxDataQ;
  assign evt.parErr   = parErrQ;
  assign evt.frameErr = frameErrQ;
  assign evt.rxBrk    = rxBrkQ;
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int RESET_DIV = 1,
  parameter int ADDR_W = 3,
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              rdEn,
  input  event_t            evt,
  output cfg_t              cfg,
  output strobe_t           strb,
  output logic [BUS_W-1:0]  rdData,
  output logic [7:0]        statusVec,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_BAUD = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(4);

  logic [7:0] ier;
  logic [CHAR_W-1:0] rxHold;
  logic rxReady, overrun, frameErr, parErr, brkFlag, popRx, clrStat;

  assign popRx   = rdEn && (addr == A_DATA);
  assign clrStat = wrEn && (addr == A_CMD) && wrData[0];
  assign strb.txLoad   = wrEn && (addr == A_DATA) && evt.txHoldFree;
  assign strb.txData   = wrData[CHAR_W-1:0];
  assign strb.brkStart = wrEn && (addr == A_CMD) && wrData[1];
  assign strb.brkStop  = wrEn && (addr == A_CMD) && wrData[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '{lenCode: 2'd2, parity: PAR_NONE, multiDrop: 1'b0, mode: MODE_NORMAL,
               divisor: DIV_W'(RESET_DIV)};
      ier <= '0;
    end else if (wrEn) begin
      case (addr)
        A_CFG: begin
          cfg.lenCode   <= wrData[1:0];
          cfg.parity    <= parMode_e'(wrData[4:2]);
          cfg.multiDrop <= wrData[5];
          cfg.mode      <= chanMode_e'(wrData[7:6]);
        end
        A_BAUD:  cfg.divisor <= wrData[DIV_W-1:0];
        A_IER:   ier <= wrData[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHold <= '0; rxReady <= 1'b0; overrun <= 1'b0;
      frameErr <= 1'b0; parErr <= 1'b0; brkFlag <= 1'b0;
    end else begin
      if (clrStat) begin
        overrun <= 1'b0; frameErr <= 1'b0; parErr <= 1'b0; brkFlag <= 1'b0;
      end
      if (popRx) rxReady <= 1'b0;
      if (evt.rxDone) begin
        rxHold  <= evt.rxData;
        rxReady <= 1'b1;
        if (rxReady && !popRx) overrun <= 1'b1;
        if (evt.parErr) parErr <= 1'b1;
        if (evt.frameErr) frameErr <= 1'b1;
      end
      if (evt.rxBrk) brkFlag <= 1'b1;
    end
  end

  assign statusVec = {rxReady & rxHold[CHAR_W-1], brkFlag, parErr, frameErr, overrun,
                      evt.txIdle, evt.txHoldFree, rxReady};
  assign irq = |(statusVec & ier);

  always_comb begin
    case (addr)
      A_CFG:   rdData = BUS_W'(statusVec);
      A_BAUD:  rdData = BUS_W'(cfg.divisor);
      A_DATA:  rdData = BUS_W'(rxHold);
      A_IER:   rdData = BUS_W'(ier);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/sio_uart.sv
module sio_uart
  import sio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  output logic [15:0] rdData,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  cfg_t    cfg;
  strobe_t strb;
  event_t  evt;
  logic [7:0] statusVec;

  sio_ctrl #(.RESET_DIV(1), .ADDR_W(3), .BUS_W(16)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdEn(rdEn),
    .evt(evt), .cfg(cfg), .strb(strb), .rdData(rdData), .statusVec(statusVec), .irq(irq)
  );

  sio_datapath #(.OSR(16)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .rxd(rxd), .txd(txd), .evt(evt)
  );
endmodule

// File: rtl/sio_checker.sv
module sio_checker
  import sio_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input chanMode_e  mode,
  input logic       rxd,
  input logic       txd,
  input logic       popRx,
  input logic       clrCmd,
  input logic       rxDone,
  input logic       rxBrk,
  input logic [7:0] status
);
  // R11: remote loop ties the pins together
  p_remote_wire_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_REMOTE) |-> (txd == rxd));

  // R11: local loop keeps the line idle
  p_local_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LOCAL) |-> txd);

  // R5: a character raises ready; a read drops it
  p_ready_on_rx_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> status[0]);
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (popRx && !rxDone) |=> !status[0]);

  // R8: unread character replaced
  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && status[0] && !popRx) |=> status[3]);

  // R10: clear command empties error flags
  p_clear_errors_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clrCmd && !rxDone && !rxBrk) |=> (status[6:3] == 4'b0));
endmodule

bind sio_uart sio_checker u_chk (
  .clk(clk), .rstN(rstN), .mode(cfg.mode), .rxd(rxd), .txd(txd),
  .popRx(rdEn && (addr == 3'd2)), .clrCmd(wrEn && (addr == 3'd3) && wrData[0]),
  .rxDone(evt.rxDone), .rxBrk(evt.rxBrk), .status(statusVec)
);

// File: tb/tb_sio_uart.sv
`timescale 1ns/1ps
module tb_sio_uart;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, rxd = 1'b1;
  logic [2:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic txd, irq;
  int checks = 0, failures = 0, benchMode = 0;
  bit done = 1'b0;
  localparam int BITCLK = 32;  // 16 x divisor 2

  sio_uart dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
                .rdEn(rdEn), .rdData(rdData), .rxd(rxd), .txd(txd), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    if (a == 3'd0) benchMode = int'(d[7:6]);
  endtask

  task automatic rd(input logic [2:0] a, input bit pop, output logic [15:0] v);
    @(negedge clk); addr = a; rdEn = pop; #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // behavioural frame model: bit k of the result is the k-th bit on the line
  function automatic logic [11:0] mkFrame(input logic [8:0] d, input int nBits, input int par,
                                          input bit md, output int len);
    logic [11:0] f = '0;
    int idx = 1, ones = 0;
    for (int i = 0; i < nBits; i++) begin
      f[idx] = d[i]; ones += int'(d[i]); idx++;
    end
    if (md) begin f[idx] = d[8]; idx++; end
    else if (par != 0) begin
      case (par)
        1: f[idx] = (ones % 2) == 1;
        2: f[idx] = (ones % 2) == 0;
        3: f[idx] = 1'b0;
        default: f[idx] = 1'b1;
      endcase
      idx++;
    end
    f[idx] = 1'b1; idx++;
    len = idx;
    return f;
  endfunction

  task automatic capture(input int len, output logic [11:0] got);
    int t = 0;
    got = '0;
    while (txd !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
    repeat (BITCLK/2) @(negedge clk);
    got[0] = txd;
    for (int k = 1; k < len; k++) begin
      repeat (BITCLK) @(negedge clk);
      got[k] = txd;
    end
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic drive(input logic [11:0] bits, input int len);
    for (int k = 0; k < len; k++) begin
      rxd = bits[k];
      repeat (BITCLK) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic txCase(input string tag, input logic [7:0] cfgw, input logic [8:0] d,
                        input int nBits, input int par, input bit md);
    logic [11:0] expF, got;
    int len;
    wr(3'd0, {8'h0, cfgw});
    expF = mkFrame(d, nBits, par, md, len);
    wr(3'd2, {7'h0, d});
    capture(len, got);
    check(got == expF, tag, {20'h0, got}, {20'h0, expF});
  endtask

  // per-clock model of the pin routing
  always @(negedge clk) begin
    #5;
    if (rstN && !done) begin
      if (benchMode == 1 || benchMode == 3) check(txd === rxd, "R11 pin follow", {31'h0, txd}, {31'h0, rxd});
      else if (benchMode == 2) check(txd === 1'b1, "R11 local idle", {31'h0, txd}, 32'h1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [11:0] fr;
    int len;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rd(3'd0, 1'b0, v);
    check(v == 16'h0006, "R1 status", {16'h0, v}, 32'h6);
    check(txd === 1'b1 && irq === 1'b0, "R1 txd/irq", {30'h0, txd, irq}, 32'h2);
    wr(3'd1, 16'd2);

    // transmit formats
    txCase("R2 8N1", 8'h02, 9'h0A5, 8, 0, 1'b0);
    txCase("R3 7 even", 8'h05, 9'h035, 7, 1, 1'b0);
    txCase("R3 6 odd", 8'h08, 9'h02B, 6, 2, 1'b0);
    txCase("R3 force one", 8'h12, 9'h000, 8, 4, 1'b0);
    txCase("R4 tx address mark", 8'h22, 9'h13C, 8, 0, 1'b1);

    // clean receive with interrupt
    wr(3'd0, 16'h0002);
    wr(3'd4, 16'h0001);
    fr = mkFrame(9'h05A, 8, 0, 1'b0, len); drive(fr, len);
    rd(3'd0, 1'b0, v);
    check(v[0] && v[6:3] == 0, "R5 ready", {16'h0, v}, 32'h7);
    check(irq === 1'b1, "R12 irq high", {31'h0, irq}, 32'h1);
    rd(3'd2, 1'b1, v);
    check(v == 16'h005A, "R5 data", {16'h0, v}, 32'h5A);
    rd(3'd0, 1'b0, v);
    check(!v[0] && irq === 1'b0, "R12 irq low after read", {15'h0, irq, v}, 32'h6);
    wr(3'd4, 16'h0000);

    // parity error
    wr(3'd0, 16'h0006);
    fr = mkFrame(9'h00F, 8, 1, 1'b0, len); fr[9] = ~fr[9]; drive(fr, len);
    rd(3'd2, 1'b1, v); rd(3'd0, 1'b0, v);
    check(v[5] && !v[4], "R6 parity flag", {16'h0, v}, 32'h26);

    // clear command
    wr(3'd3, 16'h0001);
    rd(3'd0, 1'b0, v);
    check(v[6:3] == 4'h0, "R10 clear", {16'h0, v}, 32'h6);

    // framing error
    wr(3'd0, 16'h0002);
    fr = mkFrame(9'h081, 8, 0, 1'b0, len); fr[9] = 1'b0; drive(fr, len);
    rd(3'd2, 1'b1, v); rd(3'd0, 1'b0, v);
    check(v[4] && !v[5], "R7 frame flag", {16'h0, v}, 32'h16);
    wr(3'd3, 16'h0001);

    // overrun
    fr = mkFrame(9'h011, 8, 0, 1'b0, len); drive(fr, len);
    fr = mkFrame(9'h022, 8, 0, 1'b0, len); drive(fr, len);
    rd(3'd0, 1'b0, v);
    check(v[3] && v[0], "R8 overrun flag", {16'h0, v}, 32'hF);
    rd(3'd2, 1'b1, v);
    check(v == 16'h0022, "R8 newest kept", {16'h0, v}, 32'h22);
    wr(3'd3, 16'h0001);

    // break detect
    rxd = 1'b0; repeat (BITCLK * 12) @(negedge clk);
    rxd = 1'b1; repeat (60) @(negedge clk);
    rd(3'd0, 1'b0, v);
    check(v[6] && !v[0], "R9 break detect", {16'h0, v}, 32'h46);
    wr(3'd3, 16'h0001);

    // break generation
    wr(3'd3, 16'h0002);
    repeat (100) @(negedge clk);
    check(txd === 1'b0, "R9 break drive", {31'h0, txd}, 32'h0);
    wr(3'd3, 16'h0004);
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R9 break release", {31'h0, txd}, 32'h1);

    // multidrop receive
    wr(3'd0, 16'h0022);
    fr = mkFrame(9'h177, 8, 0, 1'b1, len); drive(fr, len);
    rd(3'd0, 1'b0, v);
    check(v[7] && v[0], "R4 address flag", {16'h0, v}, 32'h87);
    rd(3'd2, 1'b1, v);
    check(v == 16'h0177, "R4 ninth bit", {16'h0, v}, 32'h177);

    // local loop
    wr(3'd0, 16'h0082);
    wr(3'd2, 16'h003C);
    repeat (500) @(negedge clk);
    rd(3'd2, 1'b1, v);
    check(v == 16'h003C, "R11 local receive", {16'h0, v}, 32'h3C);

    // remote loop: receiver deaf
    wr(3'd0, 16'h00C2);
    fr = mkFrame(9'h066, 8, 0, 1'b0, len); drive(fr, len);
    rd(3'd0, 1'b0, v);
    check(!v[0], "R11 remote deaf", {16'h0, v}, 32'h6);

    // echo: receiver listens
    wr(3'd0, 16'h0042);
    fr = mkFrame(9'h099, 8, 0, 1'b0, len); drive(fr, len);
    rd(3'd2, 1'b1, v);
    check(v == 16'h0099, "R11 echo receive", {16'h0, v}, 32'h99);
    wr(3'd0, 16'h0002);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule